// File: doc/BRIEF.md
# Multi-Zone Bank-Switching Address Mapper

This block sits between an 8-bit CPU's 16-bit address bus and a program ROM of up to 512KiB. The lower half of the CPU space always reaches the first 32KiB of ROM unchanged. Above it lie four switchable windows of 16KiB, 8KiB, 4KiB and 2KiB. Each window has its own bank register, sized so that bank number and in-window offset together span exactly 19 ROM address bits. The mapping is combinational from the CPU address and the bank registers, so a CPU read sees its translated ROM address in the same cycle.

There is no data bus. Software loads a bank register by performing a port write. The port decoder elsewhere in the system turns that write into a strobe pulse. At that moment the upper address byte carries the bank number, and the two lowest address bits name the window. The block samples the strobe with its clock and loads the named register on the strobe's rising edge. While the strobe is low, the address drive enable is dropped so that the pads can release the ROM address lines.

Top module: `bank_window_mapper`

## Requirements
- R1: CPU addresses with bit 15 clear (0x0000 to 0x7FFF) map to ROM address {4'b0, A[14:0]}, and the hit flag is high.
- R2: CPU 0x8000 to 0xBFFF (16KiB window, select code 2'b11) maps to {bank3[4:0], A[13:0]}, and the hit flag is high.
- R3: CPU 0xC000 to 0xDFFF (8KiB window, select code 2'b10) maps to {bank2[5:0], A[12:0]}, and the hit flag is high.
- R4: CPU 0xE000 to 0xEFFF (4KiB window, select code 2'b01) maps to {bank1[6:0], A[11:0]}, and the hit flag is high.
- R5: CPU 0xF000 to 0xF7FF (2KiB window, select code 2'b00) maps to {bank0[7:0], A[10:0]}, and the hit flag is high.
- R6: CPU 0xF800 to 0xFFFF reaches no window. The hit flag is low there, and the ROM address is don't-care.
- R7: A strobe that is sampled high after being sampled low on the previous clock loads A[15:8] into the register picked by A[1:0]. The new mapping is visible from the next clock cycle, and the other three registers keep their values.
- R8: A register stores only as many low bits of A[15:8] as its width allows (5, 6, 7 or 8). Higher bits are dropped; for example, 0xFF written to the 16KiB register reads as bank 31.
- R9: A strobe held steadily high or steadily low loads nothing, whatever the address does.
- R10: The address drive enable is low in every cycle in which the strobe is low. The mapping and the hit flag are still produced during that time.
- R11: A synchronous reset clears all four bank registers to zero. A rising strobe edge is recognised only after the strobe has been seen low following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobe and updates the bank registers |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address; during a load it also carries bank number and window select |
| wr_strobe | input | 1 | Decoded port-write strobe, active low, loads on its rising edge |
| rom_addr | output | 19 | Translated ROM address |
| rom_hit | output | 1 | High when the CPU address falls in the fixed window or in a switchable window |
| addr_drive_en | output | 1 | High when the pads may drive rom_addr; low while the strobe is low |

## Verification
The bench builds the mapper with its default geometry: a 16-bit CPU space, a 19-bit ROM space and four windows whose smallest is 2KiB. With these values every window is reachable, and each register width from 5 to 8 bits is exercised. Writing 0xFF to the narrowest register and then reading the top of its window reaches the last ROM location, 0x7FFFF. The same geometry shows the strobe-level behaviour: loads during a steady high or steady low strobe are refused, a reset in mid-run clears the banks, and the drive enable falls while the mapping continues.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

   // Number of in-window offset bits of window k (window 0 is the smallest).
   function automatic int win_ofs(input int min_ofs, input int k);
      return min_ofs + k;
   endfunction

   // Width of the bank register of window k.
   function automatic int bank_w(input int rom_aw, input int min_ofs, input int k);
      return rom_aw - min_ofs - k;
   endfunction

   // Position of window k's register inside the flattened bank vector.
   function automatic int bank_lsb(input int rom_aw, input int min_ofs, input int k);
      int acc;
      acc = 0;
      for (int j = 0; j < k; j++) acc += rom_aw - min_ofs - j;
      return acc;
   endfunction

endpackage

// File: rtl/bmap_strobe_edge.sv
module bmap_strobe_edge (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic rise_o
);
   logic prev_q;

   // Reset to "high" so that a strobe held high through reset is not a rise.
   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= strobe_i;
   end

   assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/bmap_bank_file.sv
module bmap_bank_file
   import bmap_pkg::*;
#(
   parameter int ROM_AW  = 19,
   parameter int MIN_OFS = 11,
   parameter int NUM_WIN = 4,
   parameter int DATA_W  = 8,
   localparam int SEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int BANK_BITS = bank_lsb(ROM_AW, MIN_OFS, NUM_WIN)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we_i,
   input  logic [SEL_W-1:0]     sel_i,
   input  logic [DATA_W-1:0]    data_i,
   output logic [BANK_BITS-1:0] bank_o
);

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      localparam int BW  = bank_w(ROM_AW, MIN_OFS, k);
      localparam int LSB = bank_lsb(ROM_AW, MIN_OFS, k);

      logic [BW-1:0] bank_q;

      always_ff @(posedge clk) begin
         if (rst)
            bank_q <= '0;
         else if (we_i && (sel_i == SEL_W'(k)))
            bank_q <= data_i[BW-1:0];
      end

      assign bank_o[LSB +: BW] = bank_q;
   end

endmodule

// File: rtl/bmap_window_decode.sv
module bmap_window_decode
   import bmap_pkg::*;
#(
   parameter int CPU_AW  = 16,
   parameter int ROM_AW  = 19,
   parameter int MIN_OFS = 11,
   parameter int NUM_WIN = 4,
   localparam int BANK_BITS = bank_lsb(ROM_AW, MIN_OFS, NUM_WIN)
) (
   input  logic [CPU_AW-1:0]    cpu_addr_i,
   input  logic [BANK_BITS-1:0] bank_i,
   output logic [ROM_AW-1:0]    rom_addr_o,
   output logic                 rom_hit_o
);

   logic                           fixed_hit;
   logic [ROM_AW-1:0]              fixed_map;
   logic [NUM_WIN-1:0]             win_hit;
   logic [NUM_WIN-1:0][ROM_AW-1:0] win_map;

   // Lower half of the CPU space passes straight through.
   assign fixed_hit = ~cpu_addr_i[CPU_AW-1];
   assign fixed_map = ROM_AW'(cpu_addr_i[CPU_AW-2:0]);

   // Window k is selected by a prefix of ones followed by a single zero.
   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      localparam int OFS  = win_ofs(MIN_OFS, k);
      localparam int BW   = bank_w(ROM_AW, MIN_OFS, k);
      localparam int LSB  = bank_lsb(ROM_AW, MIN_OFS, k);
      localparam int PW   = CPU_AW - OFS;
      localparam logic [PW-1:0] PFX = {{(PW-1){1'b1}}, 1'b0};

      assign win_hit[k] = (cpu_addr_i[CPU_AW-1:OFS] == PFX);
      assign win_map[k] = {bank_i[LSB +: BW], cpu_addr_i[OFS-1:0]};
   end

   always_comb begin
      rom_addr_o = '0;
      if (fixed_hit) rom_addr_o = fixed_map;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (win_hit[k]) rom_addr_o = win_map[k];
      end
   end

   assign rom_hit_o = fixed_hit | (|win_hit);

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
   import bmap_pkg::*;
#(
   parameter int CPU_AW  = 16,
   parameter int ROM_AW  = 19,
   parameter int MIN_OFS = 11,
   parameter int NUM_WIN = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              wr_strobe,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_hit,
   output logic              addr_drive_en
);

   localparam int DATA_W    = CPU_AW / 2;
   localparam int SEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
   localparam int BANK_BITS = bank_lsb(ROM_AW, MIN_OFS, NUM_WIN);
   localparam int TOP_OFS   = MIN_OFS + NUM_WIN - 1;

   // Elaboration-time geometry checks.
   if (NUM_WIN != (1 << SEL_W)) begin : g_bad_num
      $error("NUM_WIN must be a power of two");
   end
   if (TOP_OFS != CPU_AW - 2) begin : g_bad_top
      $error("largest window must be one quarter of the CPU space");
   end
   if (ROM_AW - MIN_OFS > DATA_W) begin : g_bad_data
      $error("widest bank register exceeds the upper address byte");
   end
   if (ROM_AW - TOP_OFS < 1) begin : g_bad_narrow
      $error("narrowest bank register would be empty");
   end
   if (ROM_AW < CPU_AW - 1) begin : g_bad_fixed
      $error("ROM space cannot hold the fixed window");
   end

   logic                 load;
   logic [BANK_BITS-1:0] banks;

   bmap_strobe_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (wr_strobe),
      .rise_o   (load)
   );

   bmap_bank_file #(
      .ROM_AW  (ROM_AW),
      .MIN_OFS (MIN_OFS),
      .NUM_WIN (NUM_WIN),
      .DATA_W  (DATA_W)
   ) u_banks (
      .clk    (clk),
      .rst    (rst),
      .we_i   (load),
      .sel_i  (cpu_addr[SEL_W-1:0]),
      .data_i (cpu_addr[CPU_AW-1 -: DATA_W]),
      .bank_o (banks)
   );

   bmap_window_decode #(
      .CPU_AW  (CPU_AW),
      .ROM_AW  (ROM_AW),
      .MIN_OFS (MIN_OFS),
      .NUM_WIN (NUM_WIN)
   ) u_decode (
      .cpu_addr_i (cpu_addr),
      .bank_i     (banks),
      .rom_addr_o (rom_addr),
      .rom_hit_o  (rom_hit)
   );

   // Pads release the ROM address while a load is being set up.
   assign addr_drive_en = wr_strobe;

endmodule

// File: rtl/bmap_checker.sv
module bmap_checker #(
   parameter int CPU_AW  = 16,
   parameter int ROM_AW  = 19,
   parameter int MIN_OFS = 11
) (
   input logic              clk,
   input logic              rst,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic              wr_strobe,
   input logic [ROM_AW-1:0] rom_addr,
   input logic              rom_hit,
   input logic              addr_drive_en
);
   localparam int LO     = CPU_AW - 2;
   localparam int BW_TOP = ROM_AW - LO;
   localparam int DLSB   = CPU_AW / 2;
   localparam int SPW    = CPU_AW - MIN_OFS;
   localparam logic [SPW-1:0] SMALL_PFX = {{(SPW-1){1'b1}}, 1'b0};

   // R1: fixed window passes through.
   a_r1_fixed_window: assert property (@(posedge clk) disable iff (rst)
      !cpu_addr[CPU_AW-1] |-> (rom_hit && rom_addr == ROM_AW'(cpu_addr[CPU_AW-2:0])));

   // R5: smallest window keeps the in-window offset.
   a_r5_small_offset: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[CPU_AW-1:MIN_OFS] == SMALL_PFX) |->
         (rom_hit && rom_addr[MIN_OFS-1:0] == cpu_addr[MIN_OFS-1:0]));

   // R6: top of the space reaches no window.
   a_r6_top_unmapped: assert property (@(posedge clk) disable iff (rst)
      (&cpu_addr[CPU_AW-1:MIN_OFS]) |-> !rom_hit);

   // R7: a rising strobe with select 11 loads the largest window's bank.
   a_r7_load_top: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(wr_strobe) && (&cpu_addr[1:0])) |=>
         (cpu_addr[CPU_AW-1:LO] != 2'b10 ||
          rom_addr[ROM_AW-1:LO] == $past(cpu_addr[DLSB +: BW_TOP])));

   // R9: a steady high strobe leaves the largest window's mapping unchanged.
   a_r9_no_load_steady: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[CPU_AW-1:LO] == 2'b10 && $stable(cpu_addr) &&
       wr_strobe && $past(wr_strobe) && $past(wr_strobe, 2) && !$past(rst, 2))
         |-> $stable(rom_addr));

   // R10: drive enable drops while the strobe is low, translation continues.
   a_r10_release: assert property (@(posedge clk) disable iff (rst)
      (!wr_strobe && !cpu_addr[CPU_AW-1]) |-> (!addr_drive_en && rom_hit));

   // R11: right after reset the largest window points at bank 0.
   a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && cpu_addr[CPU_AW-1:LO] == 2'b10) |->
         (rom_addr[ROM_AW-1:LO] == '0));

endmodule

bind bank_window_mapper bmap_checker #(
   .CPU_AW  (CPU_AW),
   .ROM_AW  (ROM_AW),
   .MIN_OFS (MIN_OFS)
) u_chk (.*);

// File: tb/sim_bank_window_mapper.sv
`timescale 1ns/1ps
module sim_bank_window_mapper;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic        wr_strobe = 1'b1;
   logic [18:0] rom_addr;
   logic        rom_hit;
   logic        addr_drive_en;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Reference bank model (widths 8, 7, 6, 5 for select 0..3).
   logic [7:0] bk [4];

   // Scoreboard queues.
   logic [15:0] q_addr [$];
   logic [18:0] q_rom  [$];
   logic        q_hit  [$];
   logic        q_en   [$];
   string       q_req  [$];

   always #10 clk = ~clk;   // 50 MHz

   bank_window_mapper u0 (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .wr_strobe(wr_strobe),
      .rom_addr(rom_addr), .rom_hit(rom_hit), .addr_drive_en(addr_drive_en)
   );

   function automatic void model(input logic [15:0] a, output logic [18:0] r,
                                 output logic h);
      h = 1'b1;
      if (!a[15])       r = {4'b0, a[14:0]};
      else if (!a[14])  r = {bk[3][4:0], a[13:0]};
      else if (!a[13])  r = {bk[2][5:0], a[12:0]};
      else if (!a[12])  r = {bk[1][6:0], a[11:0]};
      else if (!a[11])  r = {bk[0], a[10:0]};
      else begin r = '0; h = 1'b0; end
   endfunction

   task automatic clear_model();
      for (int i = 0; i < 4; i++) bk[i] = '0;
   endtask

   // Driver: present an address and queue the expected outcome.
   task automatic probe(input logic [15:0] a, input string req);
      logic [18:0] r;
      logic        h;
      @(negedge clk);
      cpu_addr = a;
      model(a, r, h);
      q_addr.push_back(a);
      q_rom.push_back(r);
      q_hit.push_back(h);
      q_en.push_back(wr_strobe);
      q_req.push_back(req);
   endtask

   // Driver: port write of bank number into window select sel.
   task automatic load_bank(input logic [1:0] sel, input logic [7:0] num);
      @(negedge clk);
      wr_strobe = 1'b0;
      cpu_addr = {num, 6'b0, sel};
      @(negedge clk);
      wr_strobe = 1'b1;
      bk[sel] = num & (8'hFF >> sel);
      @(negedge clk);
   endtask

   // Monitor: compare queued expectations away from the clock edge.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (q_addr.size() > 0) begin
            logic [15:0] a;
            logic [18:0] r;
            logic        h, e;
            string       req;
            a = q_addr.pop_front();
            r = q_rom.pop_front();
            h = q_hit.pop_front();
            e = q_en.pop_front();
            req = q_req.pop_front();
            checks++;
            if (rom_hit !== h || addr_drive_en !== e || (h && rom_addr !== r)) begin
               failures++;
               $display("FAIL %s addr=%h: rom=%h hit=%b en=%b expected rom=%h hit=%b en=%b",
                        req, a, rom_addr, rom_hit, addr_drive_en, r, h, e);
            end
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R11: reset state, all banks zero.
      probe(16'h8000, "R11");
      probe(16'hC000, "R11");
      probe(16'hE000, "R11");
      probe(16'hF000, "R11");

      // R1: fixed window.
      probe(16'h0000, "R1");
      probe(16'h7FFF, "R1");
      probe(16'h1234, "R1");

      // R2: 16KiB window, bank 1.
      load_bank(2'b11, 8'h01);
      probe(16'h8000, "R2");
      probe(16'hBFFF, "R2");

      // R3: 8KiB window, bank 0x2A.
      load_bank(2'b10, 8'h2A);
      probe(16'hC123, "R3");
      probe(16'hDFFF, "R3");
      // R7: other registers unchanged by this load.
      probe(16'h8004, "R7");
      probe(16'hE004, "R7");

      // R4: 4KiB window, bank 0x55.
      load_bank(2'b01, 8'h55);
      probe(16'hE9AB, "R4");

      // R5: 2KiB window, bank 0xA5.
      load_bank(2'b00, 8'hA5);
      probe(16'hF000, "R5");
      probe(16'hF7FF, "R5");

      // R6: unmapped top.
      probe(16'hF800, "R6");
      probe(16'hFFFF, "R6");

      // R8: oversize bank numbers truncated.
      load_bank(2'b11, 8'hFF);
      probe(16'hBFFF, "R8");
      load_bank(2'b10, 8'hFF);
      probe(16'hC000, "R8");
      load_bank(2'b01, 8'hF3);
      probe(16'hE000, "R8");

      // R9: strobe held high while a load-looking address is present.
      @(negedge clk);
      cpu_addr = 16'h1F03;
      repeat (3) @(negedge clk);
      probe(16'h8000, "R9");

      // R10 / R9: strobe held low, address changes, no load, enable low.
      @(negedge clk);
      wr_strobe = 1'b0;
      cpu_addr = 16'h0A03;
      repeat (3) @(negedge clk);
      probe(16'h8000, "R10");
      probe(16'h1234, "R10");
      probe(16'h8010, "R9");

      // R7: rise loads the address present at the rising edge.
      @(negedge clk);
      cpu_addr = 16'h1403;
      @(negedge clk);
      wr_strobe = 1'b1;
      bk[3] = 8'h14;
      @(negedge clk);
      probe(16'h8000, "R7");

      // R11: mid-run reset clears every bank.
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      clear_model();
      probe(16'hA000, "R11");
      probe(16'hD000, "R11");
      probe(16'hE800, "R11");
      probe(16'hF400, "R11");

      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule